// File: doc/BRIEF.md
# Serial Flash Instruction Front-End with Single/Quad Line Switching

This block sits behind the pins of a serial flash device and turns the host's serial clock, chip select and four data lines into whole instruction bytes. All pins are oversampled by the device's internal clock `clk`. Pin edges are detected after a synchronizer. An instruction is assembled either one bit per serial clock on data line 0, or four bits per serial clock on all four lines. The choice depends on a mode flag that two opcodes toggle at runtime.

Each completed instruction is reported as an opcode with a one-cycle valid strobe. When the opcode matches the configured read opcode, the block shifts bytes taken from `rd_data` back to the host. In single-line mode the bytes go out on data line 1 only. In quad mode they go out on all four lines. The output enables are active only during that data-out phase. A chip-select release, the reset pin or the reset strobe returns the front-end to a clean state.

Top module: `flash_cmd_frontend`

## Requirements
- R1: After `rst_n` is asserted, `qpi_mode` is 0, `op_valid` is 0 and `io_oe` is 4'b0000.
- R2: In single-line mode an instruction is 8 rising serial-clock edges with `ce_n` low, sampling `io_in[0]`, most significant bit first. The completed byte appears on `op_code` with `op_valid` high for exactly one `clk` cycle.
- R3: Capture gives the same result whether the serial clock idles low or high while `ce_n` is high.
- R4: Opcode 8'h35 completed in single-line mode sets `qpi_mode` to 1, in the same cycle as its `op_valid`. When it is completed in quad mode, the mode does not change.
- R5: In quad mode an instruction is 2 rising serial-clock edges, each sampling `io_in[3:0]` with `io_in[3]` as the most significant bit. The upper nibble comes first.
- R6: Opcode 8'hF5 completed in quad mode clears `qpi_mode`. When it is completed in single-line mode, the mode does not change. In both cases the opcode is still reported.
- R7: `ce_n` going high before the final bit discards the partial instruction: no `op_valid` is produced. The next frame starts capture from bit 0.
- R8: A one-cycle `sw_rst` pulse forces `qpi_mode` to 0 and ends any frame in progress.
- R9: After the read opcode (default 8'h05) in single-line mode, each falling serial-clock edge drives the next bit of `rd_data`, most significant first, on `io_out[1]` with `io_oe` = 4'b0010. `rd_data` is reloaded after every 8 bits.
- R10: After the read opcode in quad mode, each falling edge drives the next nibble of `rd_data`, upper nibble first, on `io_out[3:0]` with `io_oe` = 4'b1111.
- R11: `io_oe` is 4'b0000 outside a read data-out phase, including after a non-read opcode and after `ce_n` returns high.
- R12: After a non-read opcode, further serial clocks in the same frame are ignored: no second `op_valid` appears and the mode does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst | input | 1 | Synchronous reset strobe, returns to single-line mode |
| sck | input | 1 | Host serial clock |
| ce_n | input | 1 | Host chip select, active low |
| io_in | input | 4 | Data line inputs, bit 0 is the single-line input |
| rd_data | input | 8 | Byte to return during a read data-out phase |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Per-line output enables |
| op_code | output | 8 | Last completed instruction byte |
| op_valid | output | 1 | One-cycle strobe for a completed instruction |
| qpi_mode | output | 1 | 1 = quad-line mode, 0 = single-line mode |

## Verification
The hardest situations to reach are the mode-dependent corners. One is an opcode that means something only in the other mode: 8'h35 sent in quad mode, or 8'hF5 sent in single-line mode. The other is a partial instruction cut off by chip select. The stimulus reaches these by chaining frames so that the mode is known from earlier checks. It sends a five-bit fragment of the mode-switch opcode, then a complete one, which shows that the bit counter realigned. It also sends a switch opcode after a non-read opcode within one frame, which must not change the mode. Both serial-clock idle levels are used across these frames.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam int BYTE_W = 8;
  localparam int IO_W   = 4;

  localparam logic [BYTE_W-1:0] OPC_QUAD_ENTER = 8'h35;
  localparam logic [BYTE_W-1:0] OPC_QUAD_LEAVE = 8'hF5;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_IDLE = 2'd2
  } phase_e;
endpackage

// File: rtl/sfe_pin_sync.sv
module sfe_pin_sync #(
  parameter int             W      = 6,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sfe_edge_detect.sv
module sfe_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/sfe_cmd_capture.sv
module sfe_cmd_capture
  import flash_fe_pkg::*;
#(
  parameter logic [BYTE_W-1:0] READ_OP = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              sel,
  input  logic              rise,
  input  logic              quad,
  input  logic [IO_W-1:0]   io_s,
  output logic              fire,
  output logic [BYTE_W-1:0] fire_byte,
  output logic              in_data,
  output logic              op_valid,
  output logic [BYTE_W-1:0] op_code
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_SGL  = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] LAST_QUAD = CW'(BYTE_W / IO_W - 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  phase_e            ph_q, ph_d;
  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] opc_q, opc_d;
  logic [BYTE_W-1:0] shift_in;
  logic              last_unit;

  always_comb begin
    shift_in  = quad ? {sh_q[BYTE_W-IO_W-1:0], io_s} : {sh_q[BYTE_W-2:0], io_s[0]};
    last_unit = quad ? (cnt_q == LAST_QUAD) : (cnt_q == LAST_SGL);
    cnt_d = cnt_q;
    sh_d  = sh_q;
    ph_d  = ph_q;
    fire  = 1'b0;
    if (sw_rst || !sel) begin
      cnt_d = '0;
      ph_d  = PH_CMD;
    end else if (rise && (ph_q == PH_CMD)) begin
      sh_d = shift_in;
      if (last_unit) begin
        cnt_d = '0;
        fire  = 1'b1;
        ph_d  = (shift_in == READ_OP) ? PH_DATA : PH_IDLE;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    vld_d = fire;
    opc_d = fire ? shift_in : opc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      ph_q  <= PH_CMD;
      vld_q <= 1'b0;
      opc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      ph_q  <= ph_d;
      vld_q <= vld_d;
      opc_q <= opc_d;
    end
  end

  assign fire_byte = shift_in;
  assign in_data   = (ph_q == PH_DATA) && sel && !sw_rst;
  assign op_valid  = vld_q;
  assign op_code   = opc_q;
endmodule

// File: rtl/sfe_mode_ctl.sv
module sfe_mode_ctl
  import flash_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              fire,
  input  logic [BYTE_W-1:0] fire_byte,
  output logic              quad
);
  logic quad_q, quad_d;

  always_comb begin
    quad_d = quad_q;
    if (sw_rst) begin
      quad_d = 1'b0;
    end else if (fire) begin
      if (!quad_q && (fire_byte == OPC_QUAD_ENTER)) quad_d = 1'b1;
      if (quad_q && (fire_byte == OPC_QUAD_LEAVE))  quad_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quad_q <= 1'b0;
    else        quad_q <= quad_d;
  end

  assign quad = quad_q;
endmodule

// File: rtl/sfe_data_out.sv
module sfe_data_out
  import flash_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_data,
  input  logic              fall,
  input  logic              quad,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [IO_W-1:0]   io_out,
  output logic [IO_W-1:0]   io_oe
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_SGL  = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] LAST_QUAD = CW'(BYTE_W / IO_W - 1);
  localparam logic [IO_W-1:0] OE_SGL  = 4'b0010;
  localparam logic [IO_W-1:0] OE_QUAD = '1;

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IO_W-1:0]   out_q, out_d;
  logic [IO_W-1:0]   oe_q, oe_d;
  logic              last_unit;

  always_comb begin
    last_unit = quad ? (cnt_q == LAST_QUAD) : (cnt_q == LAST_SGL);
    sh_d  = sh_q;
    cnt_d = cnt_q;
    out_d = out_q;
    oe_d  = oe_q;
    if (load) begin
      sh_d  = rd_data;
      cnt_d = '0;
      oe_d  = '0;
    end else if (!in_data) begin
      oe_d = '0;
    end else if (fall) begin
      if (quad) begin
        out_d = sh_q[BYTE_W-1 -: IO_W];
        oe_d  = OE_QUAD;
      end else begin
        out_d = {2'b00, sh_q[BYTE_W-1], 1'b0};
        oe_d  = OE_SGL;
      end
      if (last_unit) begin
        sh_d  = rd_data;
        cnt_d = '0;
      end else begin
        sh_d  = quad ? {sh_q[BYTE_W-IO_W-1:0], {IO_W{1'b0}}} : {sh_q[BYTE_W-2:0], 1'b0};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign io_out = out_q;
  assign io_oe  = oe_q;
endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flash_fe_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] READ_OP     = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              sck,
  input  logic              ce_n,
  input  logic [IO_W-1:0]   io_in,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [IO_W-1:0]   io_out,
  output logic [IO_W-1:0]   io_oe,
  output logic [BYTE_W-1:0] op_code,
  output logic              op_valid,
  output logic              qpi_mode
);
  localparam int PIN_W = IO_W + 2;
  localparam logic [PIN_W-1:0] PIN_RST = {1'b1, 1'b0, {IO_W{1'b0}}};

  logic [PIN_W-1:0]  pins_s;
  logic              ce_n_s, sck_s;
  logic [IO_W-1:0]   io_s;
  logic              sck_rise, sck_fall;
  logic              quad;
  logic              fire;
  logic [BYTE_W-1:0] fire_byte;
  logic              in_data;

  sfe_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ce_n, sck, io_in}),
    .q    (pins_s)
  );

  assign ce_n_s = pins_s[PIN_W-1];
  assign sck_s  = pins_s[PIN_W-2];
  assign io_s   = pins_s[IO_W-1:0];

  sfe_edge_detect u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (sck_s),
    .rise (sck_rise),
    .fall (sck_fall)
  );

  sfe_cmd_capture #(.READ_OP(READ_OP)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_rst   (sw_rst),
    .sel      (~ce_n_s),
    .rise     (sck_rise),
    .quad     (quad),
    .io_s     (io_s),
    .fire     (fire),
    .fire_byte(fire_byte),
    .in_data  (in_data),
    .op_valid (op_valid),
    .op_code  (op_code)
  );

  sfe_mode_ctl u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_rst   (sw_rst),
    .fire     (fire),
    .fire_byte(fire_byte),
    .quad     (quad)
  );

  sfe_data_out u_dout (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (fire && (fire_byte == READ_OP)),
    .in_data(in_data),
    .fall   (sck_fall),
    .quad   (quad),
    .rd_data(rd_data),
    .io_out (io_out),
    .io_oe  (io_oe)
  );

  assign qpi_mode = quad;
endmodule

// File: rtl/flash_cmd_frontend_chk.sv
module flash_cmd_frontend_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_rst,
  input logic       qpi_mode,
  input logic       op_valid,
  input logic [7:0] op_code,
  input logic [3:0] io_oe
);
  AST_OE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0010) || (io_oe == 4'b1111)); // R11

  AST_SGL_ONLY_IO1: assert property (@(posedge clk) disable iff (!rst_n)
    (!qpi_mode && (io_oe != 4'b0000)) |-> (io_oe == 4'b0010)); // R9

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid); // R2

  AST_QUAD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qpi_mode) |-> (op_valid && (op_code == 8'h35))); // R4

  AST_QUAD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qpi_mode) |-> ((op_valid && (op_code == 8'hF5)) || $past(sw_rst))); // R6

  AST_SW_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !qpi_mode); // R8
endmodule

bind flash_cmd_frontend flash_cmd_frontend_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sw_rst  (sw_rst),
  .qpi_mode(qpi_mode),
  .op_valid(op_valid),
  .op_code (op_code),
  .io_oe   (io_oe)
);

// File: tb/flash_cmd_frontend_bench.sv
module flash_cmd_frontend_bench;
  localparam int HP = 60;

  logic       clk = 1'b0;
  logic       rst_n, sw_rst, sck, ce_n;
  logic [3:0] io_in;
  logic [7:0] rd_data;
  logic [3:0] io_out, io_oe;
  logic [7:0] op_code;
  logic       op_valid, qpi_mode;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  flash_cmd_frontend u_flash_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .sck(sck), .ce_n(ce_n),
    .io_in(io_in), .rd_data(rd_data), .io_out(io_out), .io_oe(io_oe),
    .op_code(op_code), .op_valid(op_valid), .qpi_mode(qpi_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_op(input logic [7:0] op, input string req);
    exp_q.push_back(op);
    tag_q.push_back(req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && op_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7/R12 unexpected opcode actual %h expected none", op_code);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (op_code !== e) begin
          errors++;
          $display("FAIL %s opcode actual %h expected %h", t, op_code, e);
        end
      end
    end
  end

  task automatic open_frame(input logic idle);
    sck = idle; #HP; ce_n = 1'b0; #HP;
  endtask

  task automatic close_frame(input logic idle);
    sck = idle; #HP; ce_n = 1'b1; #(2*HP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; io_in = {3'b000, b[i]}; #HP;
      sck = 1'b1; #HP;
    end
  endtask

  task automatic send_quad(input logic [7:0] b);
    sck = 1'b0; io_in = b[7:4]; #HP; sck = 1'b1; #HP;
    sck = 1'b0; io_in = b[3:0]; #HP; sck = 1'b1; #HP;
  endtask

  task automatic read_sgl(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; #HP;
      check("R9 oe", {28'd0, io_oe}, 32'h2);
      check("R9 bit", {31'd0, io_out[1]}, {31'd0, b[i]});
      sck = 1'b1; #HP;
    end
  endtask

  task automatic read_quad(input logic [7:0] b);
    for (int i = 1; i >= 0; i--) begin
      sck = 1'b0; #HP;
      check("R10 oe", {28'd0, io_oe}, 32'hF);
      check("R10 nibble", {28'd0, io_out}, {28'd0, b[i*4 +: 4]});
      sck = 1'b1; #HP;
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sw_rst = 1'b0; sck = 1'b0; ce_n = 1'b1; io_in = 4'h0; rd_data = 8'h00;
    #3; #50;
    check("R1 mode", {31'd0, qpi_mode}, 32'd0);
    check("R1 valid", {31'd0, op_valid}, 32'd0);
    check("R1 oe", {28'd0, io_oe}, 32'd0);
    rst_n = 1'b1; #40;

    // R2: single-line capture, clock idling low
    expect_op(8'h9F, "R2");
    open_frame(1'b0); send_bits(8'h9F, 8);
    check("R11 oe after non-read", {28'd0, io_oe}, 32'd0);
    close_frame(1'b0);
    check("R2 mode", {31'd0, qpi_mode}, 32'd0);

    // R3: clock idling high
    expect_op(8'hC3, "R3");
    open_frame(1'b1); send_bits(8'hC3, 8); close_frame(1'b1);

    // R7: partial 35h cut off, then full one realigns
    open_frame(1'b0); send_bits(8'h35, 5); close_frame(1'b0);
    check("R7 mode after abort", {31'd0, qpi_mode}, 32'd0);
    expect_op(8'h35, "R7");
    open_frame(1'b0); send_bits(8'h35, 8); close_frame(1'b0);
    check("R4 enter quad", {31'd0, qpi_mode}, 32'd1);

    // R4/R5: 35h in quad mode keeps mode
    expect_op(8'h35, "R5");
    open_frame(1'b0); send_quad(8'h35); close_frame(1'b0);
    check("R4 35h in quad no change", {31'd0, qpi_mode}, 32'd1);

    // R10: quad read of two bytes
    rd_data = 8'hA6;
    expect_op(8'h05, "R10");
    open_frame(1'b1); send_quad(8'h05); read_quad(8'hA6); read_quad(8'hA6); close_frame(1'b1);
    check("R11 oe after ce high", {28'd0, io_oe}, 32'd0);

    // R6: leave quad with clock idling high
    expect_op(8'hF5, "R6");
    open_frame(1'b1); send_quad(8'hF5); close_frame(1'b1);
    check("R6 leave quad", {31'd0, qpi_mode}, 32'd0);
    expect_op(8'hF5, "R6");
    open_frame(1'b0); send_bits(8'hF5, 8); close_frame(1'b0);
    check("R6 F5h in single no change", {31'd0, qpi_mode}, 32'd0);

    // R9: single-line read of two bytes
    rd_data = 8'h5C;
    expect_op(8'h05, "R9");
    open_frame(1'b0); send_bits(8'h05, 8); read_sgl(8'h5C); read_sgl(8'h5C); close_frame(1'b0);
    check("R11 oe after single read", {28'd0, io_oe}, 32'd0);

    // R12: trailing clocks after a non-read opcode
    expect_op(8'h9F, "R12");
    open_frame(1'b0); send_bits(8'h9F, 8); send_bits(8'h35, 8); close_frame(1'b0);
    check("R12 mode unchanged", {31'd0, qpi_mode}, 32'd0);

    // R8: reset strobe leaves quad mode
    expect_op(8'h35, "R4");
    open_frame(1'b0); send_bits(8'h35, 8); close_frame(1'b0);
    check("R4 enter quad again", {31'd0, qpi_mode}, 32'd1);
    sw_rst = 1'b1; #10; sw_rst = 1'b0; #20;
    check("R8 strobe to single", {31'd0, qpi_mode}, 32'd0);

    #200;
    check("R2 all opcodes seen", exp_q.size(), 32'd0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule